// File: doc/BRIEF.md
# CPU Interrupt Entry Sequencer

This block decides when a small in-order core leaves its instruction stream to service an external request, and which request it serves. Three request pins feed it. The first is a non-maskable request that is edge-triggered. The second is a maskable level request. The third is an active-low system-management level request. The core gives it two boundary strobes: one at each instruction boundary, and one between the memory moves of a long string instruction. The core also gives it the interrupt-enable flag and one-cycle retirement pulses for interrupt-return and halt instructions.

When the block accepts a request, it raises `take` for one cycle together with a kind code and an 8-bit vector. A maskable request first runs an acknowledge handshake that fetches its vector from the bus. The non-maskable vector is fixed inside the block. While a non-maskable handler is running, the block blocks further non-maskable requests and keeps at most one pending edge. It counts nested maskable entries so that only the handler's own return lifts the block. It also controls wake-up from halt.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted only in a cycle where `insn_bnd` or `str_bnd` is high, or while `halted` is high. The acknowledge request or the take strobe appears in the next cycle.
- R2: A non-maskable entry shows `take`=1, `take_kind`=2'b10 and `take_vec`=8'h02. It raises no `ack_req`.
- R3: When several requests are eligible at once, system-management (kind 2'b11) wins, then non-maskable, then maskable.
- R4: After a non-maskable entry, no further non-maskable entry happens until an interrupt-return retires at nesting depth zero.
- R5: Any number of `nmi_pin` rising edges seen while blocked leave exactly one pending request. That request is taken at the first boundary after the unblocking return, and only once.
- R6: A maskable request is acted on only while `if_flag`=1. The block raises `ack_req` and holds it until `ack_vld`. In the cycle after `ack_vld`, it emits `take` with kind 2'b01 and `take_vec` equal to the `ack_vec` sampled with `ack_vld`.
- R7: A maskable entry taken while blocked increments a nesting count. Its interrupt-return decrements that count and leaves non-maskable requests blocked.
- R8: `halted` rises the cycle after `hlt_ret`. A halt inside the non-maskable handler is left only on a maskable or system-management entry. A new non-maskable edge neither wakes it nor is lost.
- R9: A system-management entry reports `take_vec`=0. It does not change the blocked or pending non-maskable state.
- R10: A cycle with `rst`=1 clears the pending, blocked, nesting, halt and handshake state. In the following cycle `take`, `ack_req` and `halted` are all 0.
- R11: Pins pass a two-flop synchronizer. A non-maskable edge is detected against a registered copy of the synchronized level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_pin | input | 1 | Non-maskable request, rising edge |
| intr_pin | input | 1 | Maskable request, level |
| smi_n_pin | input | 1 | System-management request, active low level |
| insn_bnd | input | 1 | Instruction boundary strobe |
| str_bnd | input | 1 | String iteration boundary strobe |
| if_flag | input | 1 | Interrupt-enable flag |
| iret_ret | input | 1 | Interrupt-return retired |
| hlt_ret | input | 1 | Halt retired |
| ack_vld | input | 1 | Acknowledge vector valid |
| ack_vec | input | 8 | Vector returned by acknowledge |
| ack_req | output | 1 | Acknowledge cycle requested |
| take | output | 1 | One-cycle interrupt entry strobe |
| take_kind | output | 2 | 01 maskable, 10 non-maskable, 11 system-management |
| take_vec | output | 8 | Entry vector |
| halted | output | 1 | Core is held in halt |

## Verification
A wrong pending flag shows up as a missing non-maskable entry, or an extra one, at the first boundary after an unblocking return. A wrong blocked flag or nesting count shows as an entry that comes one return too early or too late. Wrong priority logic shows as the wrong kind code in the very cycle after a shared boundary. A halt flag that is not cleared stays visible at the `halted` port one cycle after the entry that should have woken the core.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int          NEST_W  = 3,
  parameter int          VEC_W   = 8,
  parameter logic [7:0]  NMI_VEC = 8'h02
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi_pin,
  input  logic             intr_pin,
  input  logic             smi_n_pin,
  input  logic             insn_bnd,
  input  logic             str_bnd,
  input  logic             if_flag,
  input  logic             iret_ret,
  input  logic             hlt_ret,
  input  logic             ack_vld,
  input  logic [VEC_W-1:0] ack_vec,
  output logic             ack_req,
  output logic             take,
  output logic [1:0]       take_kind,
  output logic [VEC_W-1:0] take_vec,
  output logic             halted
);
  localparam logic [1:0] K_INTR = 2'b01;
  localparam logic [1:0] K_NMI  = 2'b10;
  localparam logic [1:0] K_SMI  = 2'b11;
  localparam logic [NEST_W-1:0] NEST_MAX = '1;

  logic [1:0] nmi_sy, intr_sy, smi_sy;
  logic nmi_q, nmi_pend, nmi_blk, in_ack;
  logic [NEST_W-1:0] nest;

  wire nmi_edge = nmi_sy[1] & ~nmi_q;
  wire smi_req  = ~smi_sy[1];
  wire intr_req = intr_sy[1] & if_flag;
  wire at_bnd   = insn_bnd | str_bnd | halted;
  wire can_dec  = ~in_ack & at_bnd;
  wire go_smi   = can_dec & smi_req;
  wire go_nmi   = can_dec & ~smi_req & nmi_pend & ~nmi_blk;
  wire go_ack   = can_dec & ~smi_req & ~(nmi_pend & ~nmi_blk) & intr_req;
  wire go_intr  = in_ack & ack_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_sy  <= 2'b00;
      intr_sy <= 2'b00;
      smi_sy  <= 2'b11;
      nmi_q   <= 1'b0;
    end else begin
      nmi_sy  <= {nmi_sy[0], nmi_pin};
      intr_sy <= {intr_sy[0], intr_pin};
      smi_sy  <= {smi_sy[0], smi_n_pin};
      nmi_q   <= nmi_sy[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_pend <= 1'b0;
      nmi_blk  <= 1'b0;
      nest     <= '0;
      in_ack   <= 1'b0;
      halted   <= 1'b0;
    end else begin
      if (nmi_edge)    nmi_pend <= 1'b1;
      else if (go_nmi) nmi_pend <= 1'b0;

      if (go_nmi) begin
        nmi_blk <= 1'b1;
        nest    <= '0;
      end else if (go_intr && nmi_blk) begin
        if (nest != NEST_MAX) nest <= nest + 1'b1;
      end else if (iret_ret && nmi_blk) begin
        if (nest != '0) nest <= nest - 1'b1;
        else            nmi_blk <= 1'b0;
      end

      if (go_ack)       in_ack <= 1'b1;
      else if (go_intr) in_ack <= 1'b0;

      if (go_smi || go_nmi || go_ack) halted <= 1'b0;
      else if (hlt_ret)               halted <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take      <= 1'b0;
      take_kind <= 2'b00;
      take_vec  <= '0;
    end else begin
      take <= go_smi | go_nmi | go_intr;
      if (go_intr) begin
        take_kind <= K_INTR;
        take_vec  <= ack_vec;
      end else if (go_smi) begin
        take_kind <= K_SMI;
        take_vec  <= '0;
      end else if (go_nmi) begin
        take_kind <= K_NMI;
        take_vec  <= VEC_W'(NMI_VEC);
      end else begin
        take_kind <= 2'b00;
        take_vec  <= '0;
      end
    end
  end

  assign ack_req = in_ack;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int NEST_W = 3,
  parameter int VEC_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             insn_bnd,
  input logic             str_bnd,
  input logic             iret_ret,
  input logic             ack_vld,
  input logic [VEC_W-1:0] ack_vec,
  input logic             ack_req,
  input logic             take,
  input logic [1:0]       take_kind,
  input logic [VEC_W-1:0] take_vec,
  input logic             halted,
  input logic             nmi_blk,
  input logic [NEST_W-1:0] nest
);
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (take && take_kind != 2'b01) |-> $past(insn_bnd || str_bnd || halted)); // R1
  AST_NMI_FIXED_VEC: assert property (@(posedge clk) disable iff (rst)
    (take && take_kind == 2'b10) |-> (take_vec == 8'h02 && !ack_req)); // R2
  AST_NMI_ONLY_UNBLOCKED: assert property (@(posedge clk) disable iff (rst)
    (take && take_kind == 2'b10) |-> $past(!nmi_blk)); // R4
  AST_INTR_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (take && take_kind == 2'b01) |-> ($past(ack_req && ack_vld) && take_vec == $past(ack_vec))); // R6
  AST_NESTED_RET_KEEPS_BLK: assert property (@(posedge clk) disable iff (rst)
    (nmi_blk && nest != '0 && iret_ret) |=> nmi_blk); // R7
  AST_SMI_NO_VEC: assert property (@(posedge clk) disable iff (rst)
    (take && take_kind == 2'b11) |-> take_vec == '0); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (!take && !ack_req && !halted)); // R10
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.NEST_W(NEST_W), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/100ps
module irq_entry_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_pin = 0, intr_pin = 0, smi_n_pin = 1;
  logic insn_bnd = 0, str_bnd = 0, if_flag = 0, iret_ret = 0, hlt_ret = 0, ack_vld = 0;
  logic [7:0] ack_vec = 0;
  logic ack_req, take, halted;
  logic [1:0] take_kind;
  logic [7:0] take_vec;

  always #2.5 clk = ~clk;

  irq_entry_seq u_irq_entry_seq (.*);

  int checks = 0, fails = 0;
  int n_nmi = 0, n_intr = 0, n_smi = 0;
  int kinds[$];
  string tag = "R10";

  // behavioural reference
  int  pin_n[3], pin_i[2], pin_s[2];
  bit  m_pend, m_blk, m_halt, m_ack, m_take;
  int  m_depth, m_kind, m_vec;

  initial begin
    pin_n = '{0,0,0}; pin_i = '{0,0}; pin_s = '{1,1};
  end

  always @(posedge clk) begin
    if (rst) begin
      pin_n = '{0,0,0}; pin_i = '{0,0}; pin_s = '{1,1};
      m_pend = 0; m_blk = 0; m_halt = 0; m_ack = 0; m_take = 0;
      m_depth = 0; m_kind = 0; m_vec = 0;
    end else begin
      bit edge_seen, bnd, decided, took_nmi, took_intr;
      edge_seen = (pin_n[1] == 1) && (pin_n[2] == 0);
      bnd = insn_bnd || str_bnd || m_halt;
      m_take = 0; m_kind = 0; m_vec = 0;
      decided = 0; took_nmi = 0; took_intr = 0;
      if (m_ack) begin
        if (ack_vld) begin
          m_take = 1; m_kind = 1; m_vec = ack_vec; m_ack = 0; took_intr = 1;
        end
      end else if (bnd) begin
        if (pin_s[1] == 0) begin
          m_take = 1; m_kind = 3; decided = 1;
        end else if (m_pend && !m_blk) begin
          m_take = 1; m_kind = 2; m_vec = 2; decided = 1; took_nmi = 1;
        end else if (pin_i[1] == 1 && if_flag) begin
          m_ack = 1; decided = 1;
        end
      end
      if (took_nmi) begin m_blk = 1; m_depth = 0; end
      else if (took_intr && m_blk) begin if (m_depth < 7) m_depth++; end
      else if (iret_ret && m_blk) begin
        if (m_depth > 0) m_depth--; else m_blk = 0;
      end
      if (edge_seen) m_pend = 1; else if (took_nmi) m_pend = 0;
      if (decided) m_halt = 0; else if (hlt_ret) m_halt = 1;
      pin_n[2] = pin_n[1]; pin_n[1] = pin_n[0]; pin_n[0] = nmi_pin;
      pin_i[1] = pin_i[0]; pin_i[0] = intr_pin;
      pin_s[1] = pin_s[0]; pin_s[0] = smi_n_pin;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(take == m_take, tag, "take", take, m_take);
    chk(ack_req == m_ack, tag, "ack_req", ack_req, m_ack);
    chk(halted == m_halt, tag, "halted", halted, m_halt);
    if (m_take) begin
      chk(take_kind == 2'(m_kind), tag, "take_kind", take_kind, m_kind);
      chk(take_vec == 8'(m_vec), tag, "take_vec", take_vec, m_vec);
    end
    if (take) begin
      kinds.push_back(take_kind);
      case (take_kind)
        2'b01: n_intr++;
        2'b10: n_nmi++;
        2'b11: n_smi++;
        default: ;
      endcase
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic nmi_pulse();
    nmi_pin = 1; cyc(2); nmi_pin = 0; cyc(2);
  endtask
  task automatic iret();
    iret_ret = 1; cyc(1); iret_ret = 0; cyc(5);
  endtask
  task automatic serve_intr(input logic [7:0] v);
    int guard = 0;
    while (!ack_req && guard < 40) begin cyc(1); guard++; end
    chk(ack_req, "R6", "ack_req raised", ack_req, 1);
    cyc(2);
    ack_vec = v; ack_vld = 1; if_flag = 0; intr_pin = 0;
    cyc(1); ack_vld = 0; cyc(4);
  endtask

  initial begin
    cyc(3);
    chk(!take && !ack_req && !halted, "R10", "idle after reset", take, 0);
    rst = 0; cyc(2);

    tag = "R1";
    intr_pin = 1; if_flag = 1; cyc(10);
    chk(!ack_req, "R1", "no ack without boundary", ack_req, 0);
    tag = "R6";
    insn_bnd = 1; cyc(1); insn_bnd = 0;
    serve_intr(8'h41);
    chk(n_intr == 1, "R6", "intr entries", n_intr, 1);

    intr_pin = 1; if_flag = 0; insn_bnd = 1; cyc(10);
    chk(!ack_req && n_intr == 1, "R6", "masked intr ignored", n_intr, 1);
    intr_pin = 0; cyc(4);

    tag = "R2"; nmi_pulse(); cyc(4);
    chk(n_nmi == 1, "R2", "nmi entries", n_nmi, 1);
    tag = "R5"; nmi_pulse(); nmi_pulse(); nmi_pulse(); cyc(6);
    chk(n_nmi == 1, "R4", "blocked nmi not taken", n_nmi, 1);
    iret(); cyc(2);
    chk(n_nmi == 2, "R5", "one pending nmi after return", n_nmi, 2);
    iret(); cyc(6);
    chk(n_nmi == 2, "R5", "only one pending kept", n_nmi, 2);

    tag = "R7"; nmi_pulse(); cyc(4);
    chk(n_nmi == 3, "R7", "nmi entry", n_nmi, 3);
    intr_pin = 1; if_flag = 1; serve_intr(8'h30);
    chk(n_intr == 2, "R7", "nested intr entry", n_intr, 2);
    nmi_pulse(); iret(); cyc(4);
    chk(n_nmi == 3, "R7", "nested return keeps block", n_nmi, 3);
    iret(); cyc(2);
    chk(n_nmi == 4, "R7", "handler return releases pending", n_nmi, 4);
    iret();

    tag = "R3"; insn_bnd = 0; kinds.delete();
    smi_n_pin = 0; intr_pin = 1; if_flag = 1; nmi_pulse(); cyc(4);
    insn_bnd = 1; cyc(1); insn_bnd = 0; smi_n_pin = 1; cyc(5);
    insn_bnd = 1; cyc(2); insn_bnd = 0;
    serve_intr(8'h55);
    chk(kinds.size() == 3, "R3", "entry count", kinds.size(), 3);
    if (kinds.size() == 3) begin
      chk(kinds[0] == 3, "R3", "first smi", kinds[0], 3);
      chk(kinds[1] == 2, "R3", "then nmi", kinds[1], 2);
      chk(kinds[2] == 1, "R3", "then intr", kinds[2], 1);
    end
    tag = "R9"; insn_bnd = 1;
    nmi_pulse(); smi_n_pin = 0; cyc(3); smi_n_pin = 1; cyc(5);
    chk(n_nmi == 5, "R9", "smi leaves nmi blocked", n_nmi, 5);
    iret(); iret(); cyc(2);
    chk(n_nmi == 6, "R9", "pending kept across smi", n_nmi, 6);
    iret();

    tag = "R8"; nmi_pulse(); cyc(3); insn_bnd = 0;
    hlt_ret = 1; cyc(1); hlt_ret = 0;
    chk(halted, "R8", "halted after hlt", halted, 1);
    nmi_pulse(); cyc(6);
    chk(halted && n_nmi == 7, "R8", "nmi does not wake", n_nmi, 7);
    intr_pin = 1; if_flag = 1; serve_intr(8'h66);
    chk(!halted, "R8", "intr wakes halt", halted, 0);
    insn_bnd = 1; iret(); iret(); cyc(2);
    chk(n_nmi == 8, "R8", "held nmi taken later", n_nmi, 8);

    tag = "R10"; nmi_pulse(); cyc(2);
    rst = 1; cyc(2); rst = 0; cyc(8);
    chk(n_nmi == 8, "R10", "pending cleared by reset", n_nmi, 8);
    tag = "R1"; insn_bnd = 0; str_bnd = 1;
    nmi_pulse(); cyc(3);
    chk(n_nmi == 9, "R11", "edge after reset on string boundary", n_nmi, 9);
    str_bnd = 0; cyc(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule